// File: doc/BRIEF.md
# Compressed Instruction Expander

This block turns a 16-bit compressed RISC-V instruction into the single 32-bit base instruction that does the same work, so that the decoder behind it only has to handle the base encoding. It is purely combinational. The word from fetch is presented on `instr_i`, and the expanded word appears on `instr_o` in the same cycle, together with a flag that marks the input as compressed and a flag that marks it as illegal.

The supported set is an RV32 integer subset:
- add-immediate with a full 5-bit register;
- the stack-relative word load and store;
- the register-based word load and store with 3-bit register fields;
- the four register-register logic and subtract operations;
- the two PC-relative jumps, the two register jumps and the two compare-with-zero branches.

Every other compressed encoding is reported as illegal. A word whose two lowest bits are both set is already a full-width instruction and is passed through untouched.

Top module: `rvc_expander`

## Requirements
- R1: When `instr_i[1:0]` is 11, `instr_o` equals `instr_i`, and both `illegal_o` and `compressed_o` are 0. Otherwise `compressed_o` is 1.
- R2: An illegal compressed input drives `illegal_o` high and `instr_o` to all zeros. The illegal inputs are the all-zero halfword, and any encoding outside the supported subset (for example quadrant 00 funct3 000, or the register move in quadrant 10 funct3 100 with bits [6:2] non-zero).
- R3: Quadrant 01 funct3 000 expands to addi rd,rd,imm. Here rd is bits [11:7], and imm is the sign extension of {bit 12, bits [6:2]}. rd = 0 or imm = 0 is illegal.
- R4: A 3-bit register field f (bits [9:7] or [4:2]) names register x(8+f) in the expansion.
- R5: Quadrant 10 funct3 010 expands to lw rd, off(x2). rd is bits [11:7]. off[5] is bit 12, off[4:2] is bits [6:4], off[7:6] is bits [3:2], and the other offset bits are zero. rd = 0 is illegal.
- R6: Quadrant 10 funct3 110 expands to sw rs2, off(x2). rs2 is bits [6:2], off[5:2] is bits [12:9], and off[7:6] is bits [8:7].
- R7: Quadrant 00 funct3 010 and 110 expand to lw and sw. The base register is field [9:7]. The data register is field [4:2]. off[5:3] is bits [12:10], off[2] is bit 6, and off[6] is bit 5.
- R8: Quadrant 01 with bits [15:10] = 100011 selects a register-register operation on rd'=rs1' (bits [9:7]) and rs2' (bits [4:2]). Bits [6:5] choose it: 00 sub, 01 xor, 10 or, 11 and.
- R9: Quadrant 01 funct3 101 expands to jal x0 and funct3 001 to jal x1. The signed offset bits are: [11] from bit 12, [4] from bit 11, [9:8] from bits [10:9], [10] from bit 8, [6] from bit 7, [7] from bit 6, [3:1] from bits [5:3], and [5] from bit 2.
- R10: Quadrant 10 funct3 100 with bits [6:2] = 0 expands to jalr rd, 0(rs1), where rs1 is bits [11:7]. rd is x0 when bit 12 is 0 and x1 when bit 12 is 1. rs1 = 0 is illegal.
- R11: Quadrant 01 funct3 110 and 111 expand to beq and bne of rs1' (bits [9:7]) against x0. The signed offset bits are: [8] from bit 12, [4:3] from bits [11:10], [7:6] from bits [6:5], [2:1] from bits [4:3], and [5] from bit 2.
- R12: For a compressed input, `instr_i[31:16]` has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr_i | input | 32 | Fetched word; a compressed instruction sits in the low half |
| instr_o | output | 32 | Expanded or passed-through base instruction, zero when illegal |
| compressed_o | output | 1 | Input was a 16-bit encoding |
| illegal_o | output | 1 | Compressed input is outside the supported subset or reserved |

## Verification
The embedded checks are evaluated whenever the combinational result settles. They take for granted that `instr_i` holds a fully known value when sampled, and that no stale mix of old and new bits is present. The bench therefore changes the input only right after a rising clock edge and reads the outputs at the following falling edge. Random words are built by first choosing one of the four quadrants and then filling every other bit, so all forms appear with defined values. This includes reserved ones and full-width words with random upper halves.

// File: rtl/rvc_xpand_pkg.sv
package rvc_xpand_pkg;

  localparam int unsigned ILEN   = 32;
  localparam int unsigned CLEN   = 16;
  localparam int unsigned RIDX   = 5;
  localparam int unsigned CRIDX  = 3;
  localparam int unsigned IMMW   = 12;
  localparam int unsigned JIMMW  = 21;
  localparam int unsigned BIMMW  = 13;

  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;

  localparam logic [RIDX-1:0] REG_ZERO = 5'd0;
  localparam logic [RIDX-1:0] REG_LINK = 5'd1;
  localparam logic [RIDX-1:0] REG_SP   = 5'd2;

  typedef enum logic [3:0] {
    K_ILLEGAL, K_ADDI, K_LWSP, K_SWSP, K_LW, K_SW,
    K_ARITH, K_JUMP, K_JREG, K_BRZ
  } form_e;

  // short register field -> x8..x15
  function automatic logic [RIDX-1:0] widen_reg(input logic [CRIDX-1:0] f);
    return {2'b01, f};
  endfunction

  function automatic logic [IMMW-1:0] imm_addi(input logic [CLEN-1:0] h);
    return {{(IMMW-6){h[12]}}, h[12], h[6:2]};
  endfunction

  function automatic logic [IMMW-1:0] off_sp_load(input logic [CLEN-1:0] h);
    return {4'b0, h[3:2], h[12], h[6:4], 2'b00};
  endfunction

  function automatic logic [IMMW-1:0] off_sp_store(input logic [CLEN-1:0] h);
    return {4'b0, h[8:7], h[12:9], 2'b00};
  endfunction

  function automatic logic [IMMW-1:0] off_reg_mem(input logic [CLEN-1:0] h);
    return {5'b0, h[5], h[12:10], h[6], 2'b00};
  endfunction

  function automatic logic [JIMMW-1:0] off_jump(input logic [CLEN-1:0] h);
    logic [11:0] o;
    o = {h[12], h[8], h[10:9], h[6], h[7], h[2], h[11], h[5:3], 1'b0};
    return {{(JIMMW-12){o[11]}}, o};
  endfunction

  function automatic logic [BIMMW-1:0] off_branch(input logic [CLEN-1:0] h);
    logic [8:0] o;
    o = {h[12], h[6:5], h[2], h[11:10], h[4:3], 1'b0};
    return {{(BIMMW-9){o[8]}}, o};
  endfunction

  function automatic logic [ILEN-1:0] pack_i(input logic [IMMW-1:0] imm,
      input logic [RIDX-1:0] rs1, input logic [2:0] f3,
      input logic [RIDX-1:0] rd, input logic [6:0] opc);
    return {imm, rs1, f3, rd, opc};
  endfunction

  function automatic logic [ILEN-1:0] pack_s(input logic [IMMW-1:0] imm,
      input logic [RIDX-1:0] rs2, input logic [RIDX-1:0] rs1,
      input logic [2:0] f3);
    return {imm[11:5], rs2, rs1, f3, imm[4:0], OPC_STORE};
  endfunction

  function automatic logic [ILEN-1:0] pack_r(input logic [6:0] f7,
      input logic [RIDX-1:0] rs2, input logic [RIDX-1:0] rs1,
      input logic [2:0] f3, input logic [RIDX-1:0] rd);
    return {f7, rs2, rs1, f3, rd, OPC_OP};
  endfunction

  function automatic logic [ILEN-1:0] pack_b(input logic [BIMMW-1:0] imm,
      input logic [RIDX-1:0] rs1, input logic [2:0] f3);
    return {imm[12], imm[10:5], REG_ZERO, rs1, f3, imm[4:1], imm[11], OPC_BRANCH};
  endfunction

  function automatic logic [ILEN-1:0] pack_j(input logic [JIMMW-1:0] imm,
      input logic [RIDX-1:0] rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], rd, OPC_JAL};
  endfunction

endpackage

// File: rtl/rvc_form_sel.sv
module rvc_form_sel
  import rvc_xpand_pkg::*;
(
  input  logic [CLEN-1:0] half_i,
  output form_e           form_o
);
  logic [1:0]      quad;
  logic [2:0]      f3;
  logic [RIDX-1:0] big_rd;
  logic            rd_nz;
  logic            imm_nz;
  logic            low_nz;

  assign quad   = half_i[1:0];
  assign f3     = half_i[15:13];
  assign big_rd = half_i[11:7];
  assign rd_nz  = |big_rd;
  assign imm_nz = |{half_i[12], half_i[6:2]};
  assign low_nz = |half_i[6:2];

  always_comb begin
    form_o = K_ILLEGAL;
    case (quad)
      2'b00: begin
        if (f3 == 3'b010) form_o = K_LW;
        else if (f3 == 3'b110) form_o = K_SW;
      end
      2'b01: begin
        case (f3)
          3'b000: if (rd_nz && imm_nz) form_o = K_ADDI;
          3'b001, 3'b101: form_o = K_JUMP;
          3'b100: if (half_i[12:10] == 3'b011) form_o = K_ARITH;
          3'b110, 3'b111: form_o = K_BRZ;
          default: form_o = K_ILLEGAL;
        endcase
      end
      2'b10: begin
        case (f3)
          3'b010: if (rd_nz) form_o = K_LWSP;
          3'b110: form_o = K_SWSP;
          3'b100: if (!low_nz && rd_nz) form_o = K_JREG;
          default: form_o = K_ILLEGAL;
        endcase
      end
      default: form_o = K_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/rvc_word_build.sv
module rvc_word_build
  import rvc_xpand_pkg::*;
(
  input  logic [CLEN-1:0] half_i,
  input  form_e           form_i,
  output logic [ILEN-1:0] word_o
);
  logic [RIDX-1:0] reg_hi;   // widened bits [9:7]
  logic [RIDX-1:0] reg_lo;   // widened bits [4:2]
  logic [RIDX-1:0] big_rd;
  logic [2:0]      arith_f3;
  logic [6:0]      arith_f7;

  assign reg_hi = widen_reg(half_i[9:7]);
  assign reg_lo = widen_reg(half_i[4:2]);
  assign big_rd = half_i[11:7];

  always_comb begin
    case (half_i[6:5])
      2'b00:   arith_f3 = 3'b000;
      2'b01:   arith_f3 = 3'b100;
      2'b10:   arith_f3 = 3'b110;
      default: arith_f3 = 3'b111;
    endcase
    arith_f7 = (half_i[6:5] == 2'b00) ? 7'b0100000 : 7'b0000000;
  end

  always_comb begin
    case (form_i)
      K_ADDI:  word_o = pack_i(imm_addi(half_i), big_rd, 3'b000, big_rd, OPC_OPIMM);
      K_LWSP:  word_o = pack_i(off_sp_load(half_i), REG_SP, 3'b010, big_rd, OPC_LOAD);
      K_SWSP:  word_o = pack_s(off_sp_store(half_i), half_i[6:2], REG_SP, 3'b010);
      K_LW:    word_o = pack_i(off_reg_mem(half_i), reg_hi, 3'b010, reg_lo, OPC_LOAD);
      K_SW:    word_o = pack_s(off_reg_mem(half_i), reg_lo, reg_hi, 3'b010);
      K_ARITH: word_o = pack_r(arith_f7, reg_lo, reg_hi, arith_f3, reg_hi);
      K_JUMP:  word_o = pack_j(off_jump(half_i), half_i[15] ? REG_ZERO : REG_LINK);
      K_JREG:  word_o = pack_i('0, big_rd, 3'b000,
                               half_i[12] ? REG_LINK : REG_ZERO, OPC_JALR);
      K_BRZ:   word_o = pack_b(off_branch(half_i), reg_hi, {2'b00, half_i[13]});
      default: word_o = '0;
    endcase
  end
endmodule

// File: rtl/rvc_expander.sv
module rvc_expander
  import rvc_xpand_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [31:0] instr_o,
  output logic        compressed_o,
  output logic        illegal_o
);
  logic [CLEN-1:0] half;
  logic            full_width;
  form_e           form;
  logic [ILEN-1:0] expanded;
  logic            form_bad;

  assign half       = instr_i[CLEN-1:0];
  assign full_width = &instr_i[1:0];

  rvc_form_sel u_sel (
    .half_i (half),
    .form_o (form)
  );

  rvc_word_build u_build (
    .half_i (half),
    .form_i (form),
    .word_o (expanded)
  );

  assign form_bad     = (form == K_ILLEGAL);
  assign compressed_o = !full_width;
  assign illegal_o    = compressed_o && form_bad;
  assign instr_o      = full_width ? instr_i : (form_bad ? '0 : expanded);

  always_comb begin
    AST_PASS_THROUGH: assert (compressed_o || (instr_o == instr_i && !illegal_o)); // R1
    AST_ILLEGAL_ZEROED: assert (!illegal_o || instr_o == '0); // R2
    AST_LEGAL_IS_BASE: assert (illegal_o || instr_o[1:0] == 2'b11); // R2
    AST_SHORT_REGS_HIGH: assert (!(compressed_o && form == K_ARITH) || (instr_o[11:10] == 2'b01 && instr_o[19:18] == 2'b01 && instr_o[24:23] == 2'b01)); // R4
    AST_SP_BASE: assert (!(compressed_o && (form == K_LWSP || form == K_SWSP)) || instr_o[19:15] == REG_SP); // R5
    AST_BRANCH_ZERO: assert (!(compressed_o && form == K_BRZ) || (instr_o[24:20] == REG_ZERO && instr_o[6:0] == OPC_BRANCH)); // R11
    AST_JREG_SRC: assert (!(compressed_o && form == K_JREG) || instr_o[19:15] != REG_ZERO); // R10
  end
endmodule

// File: tb/rvc_expander_test.sv
module rvc_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] instr_o;
  logic        compressed_o;
  logic        illegal_o;
  int          checks = 0;
  int          errors = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  rvc_expander uut (
    .instr_i      (instr_i),
    .instr_o      (instr_o),
    .compressed_o (compressed_o),
    .illegal_o    (illegal_o)
  );

  // independent model: offsets summed from bit weights, then placed
  function automatic logic [32:0] golden(input logic [31:0] w, output string tag);
    logic [15:0] h;
    logic [31:0] r;
    logic        bad;
    logic [20:0] j;
    logic [12:0] b;
    int off, rd, rs1, rs2, imm, f3, f7;
    h = w[15:0]; r = '0; bad = 1'b1; tag = "R2";
    if (w[1:0] == 2'b11) begin
      tag = "R1";
      return {1'b0, w};
    end
    case ({h[1:0], h[15:13]})
      5'b00_010: begin
        tag = "R7";
        off = int'(h[12:10]) * 8 + (h[6] ? 4 : 0) + (h[5] ? 64 : 0);
        rd = 8 + int'(h[4:2]); rs1 = 8 + int'(h[9:7]);
        r = (off << 20) | (rs1 << 15) | (2 << 12) | (rd << 7) | 3; bad = 0;
      end
      5'b00_110: begin
        tag = "R7";
        off = int'(h[12:10]) * 8 + (h[6] ? 4 : 0) + (h[5] ? 64 : 0);
        rs2 = 8 + int'(h[4:2]); rs1 = 8 + int'(h[9:7]);
        r = ((off >> 5) << 25) | (rs2 << 20) | (rs1 << 15) | (2 << 12) | ((off & 31) << 7) | 35;
        bad = 0;
      end
      5'b01_000: begin
        tag = "R3";
        rd = int'(h[11:7]);
        imm = h[12] ? int'(h[6:2]) - 32 : int'(h[6:2]);
        if (rd != 0 && imm != 0) begin
          r = ((imm & 4095) << 20) | (rd << 15) | (rd << 7) | 19; bad = 0;
        end
      end
      5'b01_001, 5'b01_101: begin
        tag = "R9";
        off = (h[12] ? -2048 : 0) + (h[11] ? 16 : 0) + int'(h[10:9]) * 256 + (h[8] ? 1024 : 0)
            + (h[7] ? 64 : 0) + (h[6] ? 128 : 0) + int'(h[5:3]) * 2 + (h[2] ? 32 : 0);
        j = off[20:0];
        r = {j[20], j[10:1], j[11], j[19:12], 4'b0000, ~h[15], 7'h6f}; bad = 0;
      end
      5'b01_100: begin
        tag = "R8";
        if (h[12:10] == 3'b011) begin
          rd = 8 + int'(h[9:7]); rs2 = 8 + int'(h[4:2]);
          case (h[6:5])
            2'd0: f3 = 0;
            2'd1: f3 = 4;
            2'd2: f3 = 6;
            default: f3 = 7;
          endcase
          f7 = (h[6:5] == 2'd0) ? 32 : 0;
          r = (f7 << 25) | (rs2 << 20) | (rd << 15) | (f3 << 12) | (rd << 7) | 51; bad = 0;
        end
      end
      5'b01_110, 5'b01_111: begin
        tag = "R11";
        off = (h[12] ? -256 : 0) + int'(h[11:10]) * 8 + int'(h[6:5]) * 64
            + int'(h[4:3]) * 2 + (h[2] ? 32 : 0);
        b = off[12:0];
        rs1 = 8 + int'(h[9:7]);
        r = {b[12], b[10:5], 5'd0, rs1[4:0], 2'b00, h[13], b[4:1], b[11], 7'h63}; bad = 0;
      end
      5'b10_010: begin
        tag = "R5";
        rd = int'(h[11:7]);
        off = (h[12] ? 32 : 0) + int'(h[6:4]) * 4 + int'(h[3:2]) * 64;
        if (rd != 0) begin
          r = (off << 20) | (2 << 15) | (2 << 12) | (rd << 7) | 3; bad = 0;
        end
      end
      5'b10_110: begin
        tag = "R6";
        rs2 = int'(h[6:2]);
        off = int'(h[12:9]) * 4 + int'(h[8:7]) * 64;
        r = ((off >> 5) << 25) | (rs2 << 20) | (2 << 15) | (2 << 12) | ((off & 31) << 7) | 35;
        bad = 0;
      end
      5'b10_100: begin
        if (h[6:2] == 5'd0) begin
          tag = "R10";
          rs1 = int'(h[11:7]);
          if (rs1 != 0) begin
            r = (rs1 << 15) | ((h[12] ? 1 : 0) << 7) | 103; bad = 0;
          end
        end
      end
      default: bad = 1;
    endcase
    if (bad) r = '0;
    return {bad, r};
  endfunction

  task automatic check(input string tag, input logic [31:0] exp_w,
                       input logic exp_ill, input logic exp_c);
    checks++;
    if (instr_o !== exp_w || illegal_o !== exp_ill || compressed_o !== exp_c) begin
      errors++;
      $display("FAIL %s: in=%h got word=%h ill=%0b cmp=%0b expected word=%h ill=%0b cmp=%0b",
               tag, instr_i, instr_o, illegal_o, compressed_o, exp_w, exp_ill, exp_c);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr_i = w;
    @(negedge clk);
  endtask

  task automatic directed(input string tag, input logic [31:0] w,
                          input logic [31:0] exp_w, input logic exp_ill);
    apply(w);
    check(tag, exp_w, exp_ill, w[1:0] != 2'b11);
  endtask

  task automatic via_model(input logic [31:0] w);
    logic [32:0] g;
    string tag;
    apply(w);
    g = golden(w, tag);
    check(tag, g[31:0], g[32], w[1:0] != 2'b11);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [32:0] ga, gb;
    string ta;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R2", 32'h0, 1'b1, 1'b1);            // reset: all-zero halfword illegal
    rst_n = 1'b1;

    directed("R1", 32'h00150513, 32'h00150513, 1'b0);
    directed("R2", 32'h0000852A, 32'h0, 1'b1); // register move not supported
    directed("R2", 32'h00000004, 32'h0, 1'b1); // quadrant 00 funct3 000
    directed("R3", 32'h00000505, 32'h00150513, 1'b0);
    directed("R3", 32'h00000005, 32'h0, 1'b1); // rd = 0
    directed("R3", 32'h00000501, 32'h0, 1'b1); // imm = 0
    directed("R5", 32'h00004502, 32'h00012503, 1'b0);
    directed("R5", 32'h00004002, 32'h0, 1'b1); // rd = 0
    directed("R10", 32'h00008082, 32'h00008067, 1'b0);
    directed("R10", 32'h00009082, 32'h000080E7, 1'b0);
    directed("R10", 32'h00008002, 32'h0, 1'b1);
    directed("R11", 32'h0000C001, 32'h00040063, 1'b0);
    directed("R8", 32'h00008C05, 32'h40940433, 1'b0);   // R4: s0/s1 widened
    directed("R9", 32'h0000A001, 32'h0000006F, 1'b0);
    directed("R12", 32'hFFFF0505, 32'h00150513, 1'b0);

    // R12: same low half under two random upper halves
    for (int i = 0; i < 200; i++) begin
      logic [15:0] lo;
      lo = $urandom();
      if (lo[1:0] == 2'b11) lo[1:0] = 2'b01;
      ga = golden({16'h0, lo}, ta);
      apply({$urandom() % 65536, 16'h0} | {16'h0, lo});
      check("R12", ga[31:0], ga[32], 1'b1);
      gb = golden({16'h0, lo}, ta);
      apply({16'hA5C3, lo});
      check("R12", gb[31:0], gb[32], 1'b1);
    end

    // constrained random: quadrant picked, remaining bits free
    for (int i = 0; i < 6000; i++) begin
      logic [31:0] w;
      w = $urandom();
      w[1:0] = 2'($urandom() % 4);
      via_model(w);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
  end
endmodule